// File: doc/BRIEF.md
# Interpolated Sine LFO Oscillator

This block is a numerically controlled low-frequency oscillator for tremolo-style amplitude modulation. Each time the audio sample strobe fires, a rate word is added into a wide phase accumulator. The upper phase bits pick a position on a stored half-cycle of a sine. One further phase bit chooses the polarity of that half. The low phase bits act as a fraction that blends two neighbouring table points linearly.

The signed blended value is shifted up by half of full scale, so the output is an unsigned 16-bit gain that never goes below zero. A multiplier further down the audio path can apply it directly to the audio samples. The table is filled at elaboration by a constant function. Only one half of the wave is stored, and the negative half comes from a sign mirror.

The rate word is captured at every strobe. Each phase step uses the rate that was captured at the previous strobe, so one update of the rate is always in flight.

Top module: `lfo_sine_osc`

## Requirements
- R1: While reset (active high, synchronous) is asserted and after it is released, the output is 0x8000 and the valid flag is 0. The phase is 0 and the captured rate is 0x001000.
- R2: On each strobe cycle the phase advances by the captured rate, zero-extended to 32 bits, and `rate_i` is captured at the same edge. The first strobe after reset therefore advances the phase by 0x001000.
- R3: Changes of `rate_i` in cycles without a strobe have no effect on the phase or on the output.
- R4: The table holds 512 entries. Entry i is the nearest integer to 32767·sin(π·i/512).
- R5: The phase fields are: index = phase[24:16], fraction = phase[15:0], polarity = phase[25]. When polarity is 1 the fetched entry is negated. Phase bits 31:26 have no effect on the output.
- R6: The interpolated value is floor(A·(65535−f)/65536) + floor(B·f/65536). Here f is the fraction, A is the signed sample at the 10-bit position phase[25:16], and B is the signed sample at that position plus one, modulo 1024. B takes the polarity of its own half, so position 511 is followed by a negated entry 0 and position 1023 is followed by a positive entry 0.
- R7: The output equals the interpolated value plus 0x8000, modulo 2^16. The interpolated value always lies in [−32768, 32767].
- R8: The output and the valid flag are registered. Both reflect the phase as advanced by a strobe in the cycle after that strobe. The valid flag is high for exactly one cycle per strobe, and the output holds its value between strobes.
- R9: The phase accumulator wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| smp_stb_i | input | 1 | Audio sample strobe, one cycle per sample |
| rate_i | input | 24 | Phase increment word, captured on each strobe |
| lfo_o | output | 16 | Unsigned LFO value |
| lfo_vld_o | output | 1 | One-cycle pulse marking a new `lfo_o` |

## Verification
Two things happen at the same strobe edge: the phase advances by the previously captured rate, and a new rate word is captured. The bench changes `rate_i` at almost every strobe, including back-to-back strobes, and also between strobes. Its model applies each rate one sample late, so an output computed with the freshly presented rate does not match. The bench also steers the phase through the positions where index 511 meets entry 0 and where the polarity bit wraps, and to phases that differ only in the top bits. There it checks the blend, the sign mirror and the midpoint offset against an integer model, including the exact extremes 0xFFFE and 0x0001.

// File: rtl/lfo_sine_pkg.sv
package lfo_sine_pkg;

   // Nearest-integer half-cycle sine point, evaluated at elaboration only.
   function automatic int half_sine_point(input int idx, input int depth, input int amp);
      real ang;
      real val;
      ang = 3.14159265358979323846 * real'(idx) / real'(depth);
      val = real'(amp) * $sin(ang);
      if (val < 0.0) val = 0.0;
      return $rtoi(val + 0.5);
   endfunction

endpackage

// File: rtl/lfo_phase_acc.sv
module lfo_phase_acc #(
   parameter int          PHASE_W    = 32,
   parameter int          RATE_W     = 24,
   parameter int          FRAC_W     = 16,
   parameter int          POS_W      = 10,
   parameter logic [23:0] RESET_RATE = 24'h001000
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              stb_i,
   input  logic [RATE_W-1:0] rate_i,
   output logic [POS_W-1:0]  pos_o,
   output logic [FRAC_W-1:0] frac_o
);

   localparam int EXT_W = PHASE_W - RATE_W;

   logic [PHASE_W-1:0] phase_q;
   logic [PHASE_W-1:0] phase_nxt;
   logic [RATE_W-1:0]  rate_q;

   assign phase_nxt = phase_q + {{EXT_W{1'b0}}, rate_q};
   assign pos_o     = phase_nxt[FRAC_W +: POS_W];
   assign frac_o    = phase_nxt[FRAC_W-1:0];

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         phase_q <= '0;
         rate_q  <= RATE_W'(RESET_RATE);
      end else if (stb_i) begin
         phase_q <= phase_nxt;
         rate_q  <= rate_i;
      end
   end

   // R2: phase only moves on a strobe
   assert_phase_hold_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      !stb_i |=> $stable(phase_q));

   // R3: rate input is not captured without a strobe
   assert_rate_ignored_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      !stb_i |=> $stable(rate_q));

endmodule

// File: rtl/lfo_sine_rom.sv
module lfo_sine_rom
   import lfo_sine_pkg::*;
#(
   parameter int IDX_W  = 9,
   parameter int SAMP_W = 16
) (
   input  logic [IDX_W:0]            pos_i,
   output logic signed [SAMP_W-1:0]  samp_o
);

   localparam int DEPTH = 1 << IDX_W;
   localparam int AMP   = (1 << (SAMP_W - 1)) - 1;

   logic signed [SAMP_W-1:0] tbl [DEPTH];
   logic signed [SAMP_W-1:0] mag;

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         tbl[i] = SAMP_W'(half_sine_point(i, DEPTH, AMP));
      end
   end

   assign mag    = tbl[pos_i[IDX_W-1:0]];
   assign samp_o = pos_i[IDX_W] ? -mag : mag;

endmodule

// File: rtl/lfo_interp.sv
module lfo_interp #(
   parameter int SAMP_W = 16,
   parameter int FRAC_W = 16
) (
   input  logic signed [SAMP_W-1:0] near_i,
   input  logic signed [SAMP_W-1:0] far_i,
   input  logic [FRAC_W-1:0]        frac_i,
   output logic signed [SAMP_W:0]   sum_o,
   output logic [SAMP_W-1:0]        lfo_o
);

   localparam int PROD_W = SAMP_W + FRAC_W + 1;

   logic signed [FRAC_W:0]   w_near;
   logic signed [FRAC_W:0]   w_far;
   logic signed [PROD_W-1:0] p_near;
   logic signed [PROD_W-1:0] p_far;
   logic signed [SAMP_W-1:0] t_near;
   logic signed [SAMP_W-1:0] t_far;

   assign w_near = {1'b0, ~frac_i};
   assign w_far  = {1'b0, frac_i};
   assign p_near = PROD_W'(near_i * w_near);
   assign p_far  = PROD_W'(far_i * w_far);
   assign t_near = p_near[FRAC_W +: SAMP_W];
   assign t_far  = p_far[FRAC_W +: SAMP_W];
   assign sum_o  = {t_near[SAMP_W-1], t_near} + {t_far[SAMP_W-1], t_far};
   assign lfo_o  = sum_o[SAMP_W-1:0] ^ {1'b1, {(SAMP_W-1){1'b0}}};

endmodule

// File: rtl/lfo_sine_osc.sv
module lfo_sine_osc #(
   parameter int          PHASE_W    = 32,
   parameter int          RATE_W     = 24,
   parameter int          FRAC_W     = 16,
   parameter int          IDX_W      = 9,
   parameter int          SAMP_W     = 16,
   parameter logic [23:0] RESET_RATE = 24'h001000
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              smp_stb_i,
   input  logic [RATE_W-1:0] rate_i,
   output logic [SAMP_W-1:0] lfo_o,
   output logic              lfo_vld_o
);

   localparam int POS_W = IDX_W + 1;
   localparam int NTAP  = 2;

   if (PHASE_W < FRAC_W + POS_W) begin : g_chk_phase
      $error("phase too narrow for fraction, index and polarity fields");
   end
   if (RATE_W > PHASE_W) begin : g_chk_rate
      $error("rate word wider than phase accumulator");
   end
   if (RATE_W > 24) begin : g_chk_reset
      $error("reset rate constant is only 24 bits wide");
   end

   logic [POS_W-1:0]         pos;
   logic [FRAC_W-1:0]        frac;
   logic signed [SAMP_W-1:0] tap_samp [NTAP];
   logic signed [SAMP_W:0]   blend_sum;
   logic [SAMP_W-1:0]        blend_lfo;

   lfo_phase_acc #(
      .PHASE_W    (PHASE_W),
      .RATE_W     (RATE_W),
      .FRAC_W     (FRAC_W),
      .POS_W      (POS_W),
      .RESET_RATE (RESET_RATE)
   ) u_acc (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .stb_i  (smp_stb_i),
      .rate_i (rate_i),
      .pos_o  (pos),
      .frac_o (frac)
   );

   for (genvar t = 0; t < NTAP; t++) begin : g_tap
      localparam logic [POS_W-1:0] OFS = POS_W'(t);
      logic [POS_W-1:0] tap_pos;
      assign tap_pos = pos + OFS;
      lfo_sine_rom #(
         .IDX_W  (IDX_W),
         .SAMP_W (SAMP_W)
      ) u_rom (
         .pos_i  (tap_pos),
         .samp_o (tap_samp[t])
      );
   end

   lfo_interp #(
      .SAMP_W (SAMP_W),
      .FRAC_W (FRAC_W)
   ) u_interp (
      .near_i (tap_samp[0]),
      .far_i  (tap_samp[1]),
      .frac_i (frac),
      .sum_o  (blend_sum),
      .lfo_o  (blend_lfo)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         lfo_o     <= {1'b1, {(SAMP_W-1){1'b0}}};
         lfo_vld_o <= 1'b0;
      end else begin
         lfo_vld_o <= smp_stb_i;
         if (smp_stb_i) lfo_o <= blend_sum[SAMP_W-1:0] ^ {1'b1, {(SAMP_W-1){1'b0}}};
      end
   end

   // R8: a strobe is followed by a valid pulse
   assert_vld_after_stb_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      smp_stb_i |=> lfo_vld_o);

   // R8: no valid pulse without a strobe
   assert_vld_single_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      !smp_stb_i |=> !lfo_vld_o);

   // R8: output holds between strobes
   assert_out_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      !smp_stb_i |=> $stable(lfo_o));

   // R7: blended value stays within signed sample range
   assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      blend_sum[SAMP_W] == blend_sum[SAMP_W-1]);

   // R7: registered output equals the offset blend of the strobe cycle
   assert_offset_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      smp_stb_i |=> lfo_o == $past(blend_lfo));

endmodule

// File: tb/lfo_sine_osc_bench.sv
module lfo_sine_osc_bench;

   logic        clk = 1'b0;
   logic        rst;
   logic        stb;
   logic [23:0] rate;
   logic [15:0] lfo;
   logic        vld;

   int          n_chk  = 0;
   int          n_fail = 0;
   bit          done   = 0;

   logic [31:0] m_phase;
   logic [23:0] m_rate;
   logic [15:0] last_out;

   always #5 clk = ~clk;

   lfo_sine_osc u_lfo_sine_osc (
      .clk_i     (clk),
      .rst_i     (rst),
      .smp_stb_i (stb),
      .rate_i    (rate),
      .lfo_o     (lfo),
      .lfo_vld_o (vld)
   );

   // R4: table point
   function automatic longint tbl_pt(input int i);
      real v;
      v = 32767.0 * $sin(3.14159265358979323846 * real'(i) / 512.0);
      return longint'($rtoi(v + 0.5));
   endfunction

   // R5: signed sample at a 10-bit position
   function automatic longint samp_at(input int p);
      longint m;
      m = tbl_pt(p % 512);
      return (p >= 512) ? -m : m;
   endfunction

   // R6, R7: expected output for a phase
   function automatic logic [15:0] exp_out(input logic [31:0] ph);
      int     p;
      longint f, a, b, ta, tb, s;
      p  = int'(ph[25:16]);
      f  = longint'(ph[15:0]);
      a  = samp_at(p);
      b  = samp_at((p + 1) % 1024);
      ta = (a * (65535 - f)) >>> 16;
      tb = (b * f) >>> 16;
      s  = ta + tb + 32768;
      return s[15:0];
   endfunction

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // Entered just after a negedge; leaves just after the following negedge.
   task automatic strobe(input logic [23:0] r);
      logic [15:0] e;
      stb  = 1'b1;
      rate = r;
      @(posedge clk);
      m_phase = m_phase + {8'h00, m_rate};   // R2, R9
      m_rate  = r;
      e = exp_out(m_phase);
      @(negedge clk);
      stb = 1'b0;
      check(lfo == e, "R6/R8 output after strobe", lfo, e);
      check(vld == 1'b1, "R8 valid pulse", vld, 1);
      last_out = lfo;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         rate = 24'($urandom);
         @(negedge clk);
         check(vld == 1'b0, "R8 valid low between strobes", vld, 0);
         check(lfo == last_out, "R3 output held while rate moves", lfo, last_out);
      end
   endtask

   // Steer the model and design phase to a target value.
   task automatic goto_phase(input logic [31:0] tgt);
      logic [31:0] d;
      strobe(24'h0);
      strobe(24'h0);
      while (m_phase != tgt) begin
         d = tgt - m_phase;
         if (d > 32'h00FF_FFFF) d = 32'h00FF_FFFF;
         strobe(d[23:0]);
         strobe(24'h0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [15:0] o_a;
      void'($urandom(32'd7351));
      rst  = 1'b1;
      stb  = 1'b0;
      rate = 24'h00_0000;
      repeat (4) @(negedge clk);
      check(lfo == 16'h8000, "R1 output during reset", lfo, 16'h8000);
      rst = 1'b0;
      @(negedge clk);
      check(lfo == 16'h8000, "R1 output after reset", lfo, 16'h8000);
      check(vld == 1'b0, "R1 valid after reset", vld, 0);
      m_phase  = 32'h0;
      m_rate   = 24'h001000;
      last_out = 16'h8000;

      // R3: rate changes without strobe are ignored
      idle(5);
      // R2: first strobe uses the reset rate regardless of rate_i
      strobe(24'hABCDEF);
      check(lfo == exp_out(32'h0000_1000), "R2 first step uses reset rate", lfo, exp_out(32'h0000_1000));
      idle(3);
      strobe(24'h000200);   // applies 0xABCDEF captured earlier
      strobe(24'h123456);
      strobe(24'h000001);
      idle(2);

      // R6, R7: extremes at quarter points
      goto_phase(32'h0100_0000);
      check(lfo == 16'hFFFE, "R7 positive peak", lfo, 16'hFFFE);
      goto_phase(32'h0300_0000);
      check(lfo == 16'h0001, "R7 negative peak", lfo, 16'h0001);

      // R6: 511 -> negated entry 0, and 1023 -> positive entry 0
      goto_phase(32'h01FF_8000);
      goto_phase(32'h01FF_FFFF);
      goto_phase(32'h03FF_C000);
      goto_phase(32'h03FF_FFFF);

      // R5: top phase bits have no effect
      goto_phase(32'h0123_4567);
      o_a = lfo;
      goto_phase(32'h2D23_4567);
      check(lfo == o_a, "R5 upper phase bits ignored", lfo, o_a);

      // R9: accumulator wrap under maximum rate, back-to-back strobes
      for (int k = 0; k < 300; k++) strobe(24'hFFFFFF);
      idle(1);

      // Random phase: random rates, random gaps
      for (int k = 0; k < 3000; k++) begin
         strobe(24'($urandom));
         if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 4)));
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule